// File: doc/BRIEF.md
# Fly-by DMA transfer controller

This block sequences a four-channel DMA engine whose transfers go straight between SDRAM and an external device such as a FIFO or an FPGA. The data never lands in an on-chip buffer. When a channel is armed, enabled for direct mode and sees its device request, the block opens one SDRAM burst for it. For that burst it asserts the chip select chosen for the channel, drives the device read/write strobe from the channel's direction bit, and presents the channel's source address to the SDRAM side. Completion of the burst comes back as a single acknowledge pulse.

Each channel has a five-bit chip-select choice held in its own bank word. Five positions of that word are read as active-low selects and every other bit is ignored. When a burst starts, the block raises a one-cycle timing strobe and then watches the granted channel's request line. The request has to fall within a short window, two or three cycles long depending on the RAS-to-CAS setting. If it stays high past the window, a sticky error is set for that channel and no further burst is granted to it. Channels that are waiting are served in fixed priority order. A byte counter per channel goes down by one burst size per acknowledge, and the channel reports done when the counter reaches zero.

Top module: `flyby_dma_ctrl`

## Requirements
- R1: After reset every chip select is high, `sd_burst_req`, `cs_timing`, `ch_done`, `cfg_err` and `late_err` are low, and every channel's chip-select choice is chip select 0 (`dev_cs_n` = 5'b11110 when granted).
- R2: A bank word written with bit 26, 27, 28 or 29 low (and the other four select bits high) drives `dev_cs_n[0]`, `[1]`, `[2]` or `[3]` low during that channel's bursts. Bit 22 low drives `dev_cs_n[4]` (boot select) low. At most one `dev_cs_n` bit is ever low.
- R3: If none or more than one of bits {22,26,27,28,29} is low, `cfg_err` for that channel is high, the channel is never granted, and no chip select is driven for it.
- R4: With `ctl_dir`=1 (device is the source) a burst drives `dev_rd_wr_n`=1 and `sd_write`=1. With `ctl_dir`=0 (device is the destination) it drives both low. Both values hold steady for the whole burst.
- R5: `sd_addr` of every burst is taken from the channel's source address, in both directions. The address loaded at start advances by BURST_BYTES after each acknowledged burst.
- R6: Among channels that have `ctl_flyby` set, a nonzero count, a request high and no error, the lowest channel number is granted. A channel with `ctl_flyby` clear is never granted.
- R7: Each acknowledge lowers the granted channel's count by BURST_BYTES, saturating at zero. `ch_done` rises when the count reaches zero, and a done channel is not granted again until restarted.
- R8: If T is the cycle in which `cs_timing` is high, the granted request must be seen low in at least one of cycles T+1..T+L, where L=2 with `rcd_long`=0 and L=3 with `rcd_long`=1. Otherwise `late_err` for that channel is set. It stays set until the channel is restarted with `ch_start`.
- R9: A channel with `late_err` set starts no further burst, even while its request stays high.
- R10: Bank-word bits outside {22,26,27,28,29} do not change the chip select or the burst timing. A burst ends only on acknowledge and window close.
- R11: `cs_timing` is high for exactly the first cycle of a burst. `sd_burst_req` stays high until `sd_burst_ack`, and the chip select is released once both the acknowledge and the request window have ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_flyby | input | NCH | Per-channel direct-transfer enable |
| ctl_dir | input | NCH | Per-channel direction, 1 = device is the source |
| rcd_long | input | 1 | RAS-to-CAS setting, 0 = 2-cycle window, 1 = 3-cycle window |
| bank_we | input | NCH | Per-channel bank word write strobe |
| bank_wdata | input | 32 | Bank word, select bits at 22 and 26..29 (active low) |
| ch_start | input | NCH | Arms a channel, loading count and address and clearing its flags |
| start_count | input | CNT_W | Byte count loaded on start |
| start_addr | input | ADDR_W | SDRAM source address loaded on start |
| dma_req | input | NCH | Device request per channel |
| sd_burst_ack | input | 1 | One-cycle burst completion pulse from SDRAM side |
| sd_burst_req | output | 1 | Burst request to SDRAM side |
| sd_addr | output | ADDR_W | SDRAM address of the current burst |
| sd_write | output | 1 | 1 = SDRAM is written (device is the source) |
| cs_timing | output | 1 | One-cycle strobe at burst start |
| dev_cs_n | output | 5 | Active-low chip selects: [3:0] selects 0..3, [4] boot |
| dev_rd_wr_n | output | 1 | Device strobe, 1 = device read, 0 = device write |
| gnt_id | output | CH_W | Channel owning the current burst |
| ch_done | output | NCH | Count exhausted per channel |
| cfg_err | output | NCH | Invalid chip-select choice per channel |
| late_err | output | NCH | Sticky late request release per channel |

## Verification
The bench builds the block with its defaults: four channels, 32-byte bursts, 16-bit counts and windows of 2 and 3 cycles. With four channels it can raise competing requests on three lanes at once while a fourth lane has direct mode disabled, which exercises priority and the enable gate together. The 32-byte step lets a 40-byte count run into the saturating last burst. Both window lengths are in reach, so release at exactly the limit and one cycle past it are tried for each RAS-to-CAS setting. Random bursts, directions, acknowledge delays and filler bits in the bank word follow, checked against a model of count, address and select state kept in the bench.

// File: rtl/flyby_pkg.sv
package flyby_pkg;
  localparam int NUM_CS  = 5;
  localparam int CS_BOOT = 4;
  localparam int BANK_W  = 32;

  typedef enum logic [0:0] {ST_IDLE, ST_BURST} fsm_t;

  // Active-low select field: index 0..3 -> chip selects 0..3, index 4 -> boot.
  function automatic logic [NUM_CS-1:0] pick_sel(input logic [BANK_W-1:0] w);
    return {w[22], w[29], w[28], w[27], w[26]};
  endfunction

  function automatic logic single_low(input logic [NUM_CS-1:0] s);
    return ($countones(~s) == 1);
  endfunction
endpackage

// File: rtl/flyby_cs_sel.sv
module flyby_cs_sel
  import flyby_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NCH-1:0]                bank_we,
  input  logic [BANK_W-1:0]             bank_wdata,
  output logic [NCH-1:0][NUM_CS-1:0]    sel_n,
  output logic [NCH-1:0]                cfg_err
);
  localparam logic [NUM_CS-1:0] SEL_RST = {{(NUM_CS-1){1'b1}}, 1'b0};

  for (genvar g = 0; g < NCH; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_n[g] <= SEL_RST;
      end else if (bank_we[g]) begin
        sel_n[g] <= pick_sel(bank_wdata);
      end
    end

    assign cfg_err[g] = !single_low(sel_n[g]);

    // Right after a write, the error flag reflects the written word.
    assert_err_tracks_write_R3: assert property (@(posedge clk) disable iff (rst)
      bank_we[g] |=> (cfg_err[g] == ($countones(~pick_sel($past(bank_wdata))) != 1)));
  end
endmodule

// File: rtl/flyby_prio_arb.sv
module flyby_prio_arb #(
  parameter int NCH = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  req,
  output logic            valid,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CH_W'(i);
    end
  end
endmodule

// File: rtl/flyby_req_window.sv
module flyby_req_window #(
  parameter int SHORT_WIN = 2,
  parameter int LONG_WIN  = 3,
  localparam int W_W = $clog2(LONG_WIN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  input  logic req,
  output logic busy,
  output logic late
);
  logic           active;
  logic           dropped;
  logic [W_W-1:0] cnt;
  logic [W_W-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      dropped <= 1'b0;
      cnt     <= '0;
      lim     <= '0;
    end else if (start) begin
      active  <= 1'b1;
      dropped <= 1'b0;
      cnt     <= W_W'(1);
      lim     <= long_sel ? W_W'(LONG_WIN) : W_W'(SHORT_WIN);
    end else if (active) begin
      dropped <= dropped | !req;
      if (cnt == lim) active <= 1'b0;
      else            cnt    <= cnt + 1'b1;
    end
  end

  assign late = active && (cnt == lim) && req && !dropped;
  assign busy = start || (active && (cnt != lim));

  assert_win_bound_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt >= W_W'(1) && cnt <= lim));
  assert_win_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == lim && !start) |=> !active);
endmodule

// File: rtl/flyby_chan_state.sv
module flyby_chan_state #(
  parameter int NCH         = 4,
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NCH-1:0]              start,
  input  logic [CNT_W-1:0]            start_count,
  input  logic [ADDR_W-1:0]           start_addr,
  input  logic                        upd_burst,
  input  logic                        upd_late,
  input  logic [CH_W-1:0]             upd_ch,
  output logic [NCH-1:0]              count_nz,
  output logic [NCH-1:0][ADDR_W-1:0]  addr,
  output logic [NCH-1:0]              done,
  output logic [NCH-1:0]              late_err
);
  localparam logic [CNT_W-1:0]  STEP_C = CNT_W'(BURST_BYTES);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BURST_BYTES);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             hit;

    assign hit = (upd_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt         <= '0;
        addr[g]     <= '0;
        done[g]     <= 1'b0;
        late_err[g] <= 1'b0;
      end else if (start[g]) begin
        cnt         <= start_count;
        addr[g]     <= start_addr;
        done[g]     <= (start_count == '0);
        late_err[g] <= 1'b0;
      end else begin
        if (upd_burst && hit) begin
          if (cnt <= STEP_C) begin
            cnt     <= '0;
            done[g] <= 1'b1;
          end else begin
            cnt <= cnt - STEP_C;
          end
          addr[g] <= addr[g] + STEP_A;
        end
        if (upd_late && hit) late_err[g] <= 1'b1;
      end
    end

    assign count_nz[g] = |cnt;

    assert_done_means_empty_R7: assert property (@(posedge clk) disable iff (rst)
      done[g] |-> (cnt == '0));
    assert_late_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (late_err[g] && !start[g]) |=> late_err[g]);
  end
endmodule

// File: rtl/flyby_dma_ctrl.sv
module flyby_dma_ctrl
  import flyby_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 32,
  parameter int SHORT_WIN   = 2,
  parameter int LONG_WIN    = 3,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       ctl_flyby,
  input  logic [NCH-1:0]       ctl_dir,
  input  logic                 rcd_long,
  input  logic [NCH-1:0]       bank_we,
  input  logic [31:0]          bank_wdata,
  input  logic [NCH-1:0]       ch_start,
  input  logic [CNT_W-1:0]     start_count,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [NCH-1:0]       dma_req,
  input  logic                 sd_burst_ack,
  output logic                 sd_burst_req,
  output logic [ADDR_W-1:0]    sd_addr,
  output logic                 sd_write,
  output logic                 cs_timing,
  output logic [4:0]           dev_cs_n,
  output logic                 dev_rd_wr_n,
  output logic [CH_W-1:0]      gnt_id,
  output logic [NCH-1:0]       ch_done,
  output logic [NCH-1:0]       cfg_err,
  output logic [NCH-1:0]       late_err
);
  fsm_t                       state;
  logic                       ack_seen;
  logic [NCH-1:0][NUM_CS-1:0] sel_n;
  logic [NCH-1:0]             count_nz;
  logic [NCH-1:0][ADDR_W-1:0] ch_addr;
  logic [NCH-1:0]             eligible;
  logic                       grant_v;
  logic [CH_W-1:0]            grant_idx;
  logic                       win_busy;
  logic                       win_late;
  logic                       ack_fire;

  flyby_cs_sel #(.NCH(NCH)) u_sel (
    .clk(clk), .rst(rst), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .sel_n(sel_n), .cfg_err(cfg_err)
  );

  assign eligible = ctl_flyby & dma_req & count_nz & ~ch_done & ~late_err & ~cfg_err;

  flyby_prio_arb #(.NCH(NCH)) u_arb (
    .req(eligible), .valid(grant_v), .idx(grant_idx)
  );

  flyby_req_window #(.SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) u_win (
    .clk(clk), .rst(rst), .start(cs_timing), .long_sel(rcd_long),
    .req(dma_req[gnt_id]), .busy(win_busy), .late(win_late)
  );

  assign ack_fire = (state == ST_BURST) && sd_burst_req && sd_burst_ack;

  flyby_chan_state #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)
  ) u_chan (
    .clk(clk), .rst(rst), .start(ch_start), .start_count(start_count),
    .start_addr(start_addr), .upd_burst(ack_fire), .upd_late(win_late),
    .upd_ch(gnt_id), .count_nz(count_nz), .addr(ch_addr), .done(ch_done),
    .late_err(late_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ack_seen     <= 1'b0;
      cs_timing    <= 1'b0;
      sd_burst_req <= 1'b0;
      sd_addr      <= '0;
      sd_write     <= 1'b0;
      dev_cs_n     <= '1;
      dev_rd_wr_n  <= 1'b1;
      gnt_id       <= '0;
    end else begin
      cs_timing <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (grant_v) begin
            state        <= ST_BURST;
            ack_seen     <= 1'b0;
            cs_timing    <= 1'b1;
            sd_burst_req <= 1'b1;
            gnt_id       <= grant_idx;
            sd_addr      <= ch_addr[grant_idx];
            sd_write     <= ctl_dir[grant_idx];
            dev_rd_wr_n  <= ctl_dir[grant_idx];
            dev_cs_n     <= sel_n[grant_idx];
          end
        end
        ST_BURST: begin
          if (ack_fire) begin
            sd_burst_req <= 1'b0;
            ack_seen     <= 1'b1;
          end
          if ((ack_seen || ack_fire) && !win_busy) begin
            state       <= ST_IDLE;
            dev_cs_n    <= '1;
            dev_rd_wr_n <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cs_single_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dev_cs_n));
  assert_no_cfgerr_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && grant_v) |-> !cfg_err[grant_idx]);
  assert_dir_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BURST && !cs_timing) |-> $stable(dev_rd_wr_n));
  assert_no_late_grant_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && grant_v) |-> !late_err[grant_idx]);
  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
    cs_timing |=> !cs_timing);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (sd_burst_req && !sd_burst_ack) |=> sd_burst_req);
  assert_idle_no_cs_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (dev_cs_n == '1 && !sd_burst_req));
endmodule

// File: tb/flyby_dma_ctrl_tb_top.sv
module flyby_dma_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int ADDR_W = 32;
  localparam int CNT_W = 16;
  localparam int BURST = 32;
  localparam int CH_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] ctl_flyby = '0, ctl_dir = '0, bank_we = '0, ch_start = '0, dma_req = '0;
  logic rcd_long = 1'b0;
  logic [31:0] bank_wdata = '0;
  logic [CNT_W-1:0] start_count = '0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic sd_burst_ack = 1'b0;
  logic sd_burst_req, sd_write, cs_timing, dev_rd_wr_n;
  logic [ADDR_W-1:0] sd_addr;
  logic [4:0] dev_cs_n;
  logic [CH_W-1:0] gnt_id;
  logic [NCH-1:0] ch_done, cfg_err, late_err;

  always #5 clk = ~clk;

  flyby_dma_ctrl dut_i (
    .clk(clk), .rst(rst), .ctl_flyby(ctl_flyby), .ctl_dir(ctl_dir), .rcd_long(rcd_long),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .ch_start(ch_start),
    .start_count(start_count), .start_addr(start_addr), .dma_req(dma_req),
    .sd_burst_ack(sd_burst_ack), .sd_burst_req(sd_burst_req), .sd_addr(sd_addr),
    .sd_write(sd_write), .cs_timing(cs_timing), .dev_cs_n(dev_cs_n),
    .dev_rd_wr_n(dev_rd_wr_n), .gnt_id(gnt_id), .ch_done(ch_done),
    .cfg_err(cfg_err), .late_err(late_err)
  );

  int total = 0;
  int bad = 0;
  logic [4:0]  exp_sel [NCH];
  int          exp_cnt [NCH];
  logic [31:0] exp_addr[NCH];
  bit          exp_done[NCH];

  function automatic int win_len();
    return rcd_long ? 3 : 2;
  endfunction

  // Bank word with select index s low, the other select bits high, filler elsewhere.
  function automatic logic [31:0] bank_word(input int s, input logic [31:0] filler);
    logic [31:0] w;
    w = filler | 32'h3C40_0000;
    w[(s == 4) ? 22 : 26 + s] = 1'b0;
    return w;
  endfunction

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic bank_write(input int ch, input logic [31:0] w, input logic [4:0] sel);
    @(negedge clk);
    bank_wdata = w;
    bank_we[ch] = 1'b1;
    @(negedge clk);
    bank_we[ch] = 1'b0;
    exp_sel[ch] = sel;
  endtask

  task automatic start_ch(input int ch, input int cnt, input logic [31:0] addr);
    @(negedge clk);
    start_count = CNT_W'(cnt);
    start_addr = addr;
    ch_start[ch] = 1'b1;
    @(negedge clk);
    ch_start[ch] = 1'b0;
    exp_cnt[ch] = cnt;
    exp_addr[ch] = addr;
    exp_done[ch] = (cnt == 0);
  endtask

  task automatic wait_grant(output bit got);
    got = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cs_timing) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic grant_checks(input int ch);
    check("R6 grant id", 64'(gnt_id), 64'(ch));
    check("R2 chip select", 64'(dev_cs_n), 64'(exp_sel[ch]));
    check("R4 device strobe", 64'(dev_rd_wr_n), 64'(ctl_dir[ch]));
    check("R4 sdram write", 64'(sd_write), 64'(ctl_dir[ch]));
    check("R5 sdram address", 64'(sd_addr), 64'(exp_addr[ch]));
    check("R11 burst request", 64'(sd_burst_req), 64'd1);
  endtask

  // Request released j cycles after the strobe cycle, acknowledge after ackd cycles.
  task automatic finish_burst(input int ch, input int j, input int ackd);
    int l;
    int n;
    l = win_len();
    n = ((j > ackd) ? j : ackd) + l + 4;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == 1) check("R11 strobe width", 64'(cs_timing), 64'd0);
      if (k == ackd) begin
        check("R11 request held", 64'(sd_burst_req), 64'd1);
        check("R10 select held", 64'(dev_cs_n), 64'(exp_sel[ch]));
      end
      if (k == j) dma_req[ch] = 1'b0;
      sd_burst_ack = (k == ackd);
    end
    sd_burst_ack = 1'b0;
    dma_req[ch] = 1'b0;
    if (exp_cnt[ch] <= BURST) begin
      exp_cnt[ch] = 0;
      exp_done[ch] = 1;
    end else begin
      exp_cnt[ch] -= BURST;
    end
    exp_addr[ch] += BURST;
    @(negedge clk);
    check("R8 late flag", 64'(late_err[ch]), 64'(j > l));
    check("R7 done flag", 64'(ch_done[ch]), 64'(exp_done[ch]));
    check("R11 select released", 64'(dev_cs_n), 64'h1f);
    check("R11 request dropped", 64'(sd_burst_req), 64'd0);
  endtask

  task automatic run_burst(input int ch, input int j, input int ackd);
    bit got;
    @(negedge clk);
    dma_req[ch] = 1'b1;
    wait_grant(got);
    check("R6 burst granted", 64'(got), 64'd1);
    if (got) begin
      grant_checks(ch);
      finish_burst(ch, j, ackd);
    end else begin
      dma_req[ch] = 1'b0;
    end
  endtask

  task automatic expect_no_grant(input int ch, input string rq);
    bit seen;
    seen = 0;
    @(negedge clk);
    dma_req[ch] = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (cs_timing) seen = 1;
    end
    check(rq, 64'(seen), 64'd0);
    dma_req[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit got;
    int s, cnt, l;
    void'($urandom(32'd2024));
    for (int i = 0; i < NCH; i++) begin
      exp_sel[i] = 5'b11110;
      exp_cnt[i] = 0;
      exp_addr[i] = '0;
      exp_done[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 selects idle", 64'(dev_cs_n), 64'h1f);
    check("R1 burst request", 64'(sd_burst_req), 64'd0);
    check("R1 strobe", 64'(cs_timing), 64'd0);
    check("R1 flags", 64'({ch_done, cfg_err, late_err}), 64'd0);

    // R1 default select, R4 device as destination, R5, R7
    ctl_flyby = 4'b0111;
    ctl_dir = 4'b0000;
    start_ch(0, 3 * BURST, 32'h0000_1000);
    run_burst(0, 1, 1);
    run_burst(0, 2, 3);
    run_burst(0, 2, 6);
    expect_no_grant(0, "R7 done channel idle");

    // R4 device as source, R7 saturating final burst
    ctl_dir[0] = 1'b1;
    start_ch(0, 40, 32'h0000_2000);
    run_burst(0, 1, 2);
    run_burst(0, 2, 1);
    check("R7 done after partial", 64'(ch_done[0]), 64'd1);

    // R2 decode with random filler bits (R10)
    for (int sidx = 0; sidx < 5; sidx++) begin
      bank_write(1, bank_word(sidx, $urandom), ~(5'd1 << sidx));
      check("R3 valid choice", 64'(cfg_err[1]), 64'd0);
      ctl_dir[1] = 1'($urandom % 2);
      start_ch(1, BURST, 32'h0001_0000 + 32'(sidx) * 32'h100);
      run_burst(1, 1 + int'($urandom % 2), 1 + int'($urandom % 4));
    end

    // R3 invalid choices
    bank_write(2, 32'hEBFF_FFFF, 5'b11010);
    check("R3 two selects low", 64'(cfg_err[2]), 64'd1);
    start_ch(2, 2 * BURST, 32'h0003_0000);
    expect_no_grant(2, "R3 no grant on two lows");
    check("R3 no select driven", 64'(dev_cs_n), 64'h1f);
    bank_write(2, 32'hFFFF_FFFF, 5'b11111);
    check("R3 no select low", 64'(cfg_err[2]), 64'd1);
    expect_no_grant(2, "R3 no grant on none low");
    bank_write(2, bank_word(3, 32'h0000_00A5), 5'b10111);
    check("R3 error cleared", 64'(cfg_err[2]), 64'd0);

    // R8 and R9 for both RAS-to-CAS settings
    for (int r = 0; r < 2; r++) begin
      rcd_long = 1'(r);
      l = win_len();
      start_ch(0, 4 * BURST, 32'h0004_0000);
      run_burst(0, l, 2);
      check("R8 release at limit", 64'(late_err[0]), 64'd0);
      run_burst(0, l + 1, 1);
      check("R8 release past limit", 64'(late_err[0]), 64'd1);
      expect_no_grant(0, "R9 late channel blocked");
      start_ch(0, BURST, 32'h0005_0000);
      check("R8 restart clears", 64'(late_err[0]), 64'd0);
      run_burst(0, 1, 1);
    end

    // R6 fixed priority and enable gate
    rcd_long = 1'b0;
    start_ch(1, 2 * BURST, 32'h0006_0000);
    start_ch(2, 2 * BURST, 32'h0007_0000);
    start_ch(3, 2 * BURST, 32'h0008_0000);
    @(negedge clk);
    dma_req = 4'b1110;
    wait_grant(got);
    check("R6 contention grant", 64'(got), 64'd1);
    check("R6 lowest wins", 64'(gnt_id), 64'd1);
    dma_req = 4'b0010;
    finish_burst(1, 1, 1);
    @(negedge clk);
    dma_req = 4'b1100;
    wait_grant(got);
    check("R6 next lowest wins", 64'(gnt_id), 64'd2);
    dma_req = 4'b0100;
    finish_burst(2, 1, 2);
    expect_no_grant(3, "R6 direct mode off");

    // Random bursts over channels 0..2
    for (int it = 0; it < 25; it++) begin
      int ch;
      ch = int'($urandom % 3);
      s = int'($urandom % 5);
      ctl_dir[ch] = 1'($urandom % 2);
      rcd_long = 1'($urandom % 2);
      bank_write(ch, bank_word(s, $urandom), ~(5'd1 << s));
      cnt = (1 + int'($urandom % 3)) * BURST - int'($urandom % 2) * 7;
      start_ch(ch, cnt, {$urandom} & 32'hFFFF_FFE0);
      while (!exp_done[ch]) begin
        l = win_len();
        run_burst(ch, 1 + int'($urandom % l), 1 + int'($urandom % 4));
      end
    end

    summary();
    $finish;
  end
endmodule